// File: doc/BRIEF.md
# Byte-Lane Even Parity Unit

This block sits beside a 64-bit data bus that carries one parity bit per byte lane. For outgoing write data it produces the eight parity bits combinationally, so they leave in the same cycle as the data they protect. For incoming read data it checks every lane on each read beat, marked by a data-ready strobe, and reports a mismatch one clock later as a single-cycle error pulse that covers the whole bus.

Even parity is the rule throughout: a byte together with its parity bit must hold an even number of ones. A detected error never stops the bus transfer. The bus sequencer still finishes the cycle's beats, and this block only reports the error. When the parity-enable input is high on the failing beat, the block also pulses a trap request. On the first such trap it records the cycle address and the failing lanes in a sticky record, which stays put until a clear strobe arrives. The block has no mask input. Interrupt masking and bus locking are kept away from the trap path on purpose.

Top module: `lane_parity_unit`

## Requirements
- R1: `wrPar[i]` equals the XOR of `wrData[8i+7:8i]`, in the same cycle, so each byte together with its parity bit holds an even count of ones. This holds for every lane, whether the byte is meaningful or not.
- R2: When `dataRdy` and `isRead` are both high on a clock edge and any lane of `rdData`/`rdPar` holds an odd count of ones, `parErr` is high for exactly the following clock. A beat with clean parity leaves `parErr` low.
- R3: Parity is checked only on read beats. A beat with `isRead` low, or a cycle with `dataRdy` low, never raises `parErr`, even when the read bus holds bad parity.
- R4: `parErr` does not depend on `parEn`.
- R5: `trapReq` pulses in the same cycle as `parErr`, but only if `parEn` was high on the failing beat. No interrupt-enable or lock state gates it.
- R6: On an enabled error while no record is held, the record captures the beat's `cycAddr` into `errAddr` and the failing-lane mask into `errLanes`, where bit i marks lane i. `errValid` goes high on the next clock edge.
- R7: While `errValid` is high, later errors still pulse `parErr` and `trapReq` but leave `errAddr` and `errLanes` unchanged.
- R8: A `clrErr` high at a clock edge clears `errValid`, `errAddr` and `errLanes`. If an enabled error beat lands on the same edge, that error is captured instead.
- R9: An error with `parEn` low gives no `trapReq` and leaves the record untouched.
- R10: While reset is held, every output register is zero.
- R11: A single flipped bit in any one of the eight lanes is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 64 | Write data headed for the bus |
| wrPar | output | 8 | Generated even parity, one bit per lane |
| rdData | input | 64 | Read data from the bus |
| rdPar | input | 8 | Read parity from the bus |
| dataRdy | input | 1 | Data-ready strobe marking one beat |
| isRead | input | 1 | High when the current beat is a read |
| parEn | input | 1 | Enables trap and capture on errors |
| cycAddr | input | 32 | Address of the current bus cycle |
| clrErr | input | 1 | Clears the error record |
| parErr | output | 1 | One-clock parity error pulse |
| trapReq | output | 1 | One-clock parity trap request |
| errValid | output | 1 | Error record holds a capture |
| errAddr | output | 32 | Captured address of the first enabled error |
| errLanes | output | 8 | Captured failing-lane mask |

## Verification
A wrong sticky flag inside this block has visible effects. If the flag wrongly reads set, the next enabled error gives a trap but no new capture, so `errAddr` keeps its old value. If it wrongly reads clear, a later error overwrites the first address. Either fault shows on `errAddr` one clock after that error beat. A wrong lane mapping or parity polarity shows right away on `wrPar`, in the same cycle as the data. On reads the same fault shows on `parErr` in the cycle after a clean or corrupted beat.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
  // Strobes from control to datapath for the error record.
  typedef struct packed {
    logic capture;   // load address and lane mask
    logic clear;     // zero the record
  } ctlStrb_t;
endpackage

// File: rtl/lane_parity_dp.sv
module lane_parity_dp
  import lane_parity_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  wrPar,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANES-1:0]  rdPar,
  input  logic [ADDR_W-1:0] cycAddr,
  input  ctlStrb_t          strb,
  output logic              anyBad,
  output logic [ADDR_W-1:0] errAddr,
  output logic [LANES-1:0]  errLanes
);
  logic [LANES-1:0] laneBad;

  // One parity tree per lane for each direction.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrPar[g]   = ^wrData[g*LANE_W +: LANE_W];
    assign laneBad[g] = ^{rdData[g*LANE_W +: LANE_W], rdPar[g]};
  end

  assign anyBad = |laneBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAddr  <= '0;
      errLanes <= '0;
    end else if (strb.capture) begin
      errAddr  <= cycAddr;
      errLanes <= laneBad;
    end else if (strb.clear) begin
      errAddr  <= '0;
      errLanes <= '0;
    end
  end
endmodule

// File: rtl/lane_parity_ctl.sv
module lane_parity_ctl
  import lane_parity_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dataRdy,
  input  logic     isRead,
  input  logic     parEn,
  input  logic     clrErr,
  input  logic     anyBad,
  output ctlStrb_t strb,
  output logic     parErr,
  output logic     trapReq,
  output logic     errValid
);
  logic rdBeat;
  logic hit;

  assign rdBeat       = dataRdy & isRead;
  assign hit          = rdBeat & anyBad;
  // A clear on the same edge frees the record for the new capture.
  assign strb.capture = hit & parEn & (~errValid | clrErr);
  assign strb.clear   = clrErr & ~strb.capture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parErr   <= 1'b0;
      trapReq  <= 1'b0;
      errValid <= 1'b0;
    end else begin
      parErr  <= hit;
      trapReq <= hit & parEn;
      if (strb.capture)    errValid <= 1'b1;
      else if (strb.clear) errValid <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lane_parity_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  wrPar,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANES-1:0]  rdPar,
  input  logic              dataRdy,
  input  logic              isRead,
  input  logic              parEn,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic              clrErr,
  output logic              parErr,
  output logic              trapReq,
  output logic              errValid,
  output logic [ADDR_W-1:0] errAddr,
  output logic [LANES-1:0]  errLanes
);
  ctlStrb_t strb;
  logic     anyBad;

  lane_parity_dp #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrPar(wrPar),
    .rdData(rdData), .rdPar(rdPar), .cycAddr(cycAddr), .strb(strb),
    .anyBad(anyBad), .errAddr(errAddr), .errLanes(errLanes)
  );

  lane_parity_ctl u_ctl (
    .clk(clk), .rstN(rstN), .dataRdy(dataRdy), .isRead(isRead),
    .parEn(parEn), .clrErr(clrErr), .anyBad(anyBad), .strb(strb),
    .parErr(parErr), .trapReq(trapReq), .errValid(errValid)
  );
endmodule

// File: rtl/lane_parity_chk.sv
module lane_parity_chk #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] wrData,
  input logic [LANES-1:0]  wrPar,
  input logic              dataRdy,
  input logic              isRead,
  input logic              parEn,
  input logic              clrErr,
  input logic              parErr,
  input logic              trapReq,
  input logic              errValid,
  input logic [ADDR_W-1:0] errAddr
);
  for (genvar g = 0; g < LANES; g++) begin : gWr
    AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
      ($countones({wrData[g*LANE_W +: LANE_W], wrPar[g]}) % 2) == 0); // R1
  end

  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> $past(dataRdy && isRead)); // R2
  AST_NO_CHECK_OFF_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(dataRdy && isRead) |=> !parErr); // R3
  AST_TRAP_WITH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> parErr); // R5
  AST_TRAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(parEn)); // R9
  AST_TRAP_RECORDS: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> errValid); // R6
  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !clrErr) |=> $stable(errAddr) && errValid); // R7
endmodule

bind lane_parity_unit lane_parity_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrData(wrData), .wrPar(wrPar), .dataRdy(dataRdy),
  .isRead(isRead), .parEn(parEn), .clrErr(clrErr), .parErr(parErr),
  .trapReq(trapReq), .errValid(errValid), .errAddr(errAddr)
);

// File: tb/tb_lane_parity_unit.sv
module tb_lane_parity_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] wrData = '0;
  logic [7:0]  wrPar;
  logic [63:0] rdData = '0;
  logic [7:0]  rdPar = '0;
  logic        dataRdy = 1'b0;
  logic        isRead = 1'b0;
  logic        parEn = 1'b0;
  logic [31:0] cycAddr = '0;
  logic        clrErr = 1'b0;
  logic        parErr, trapReq, errValid;
  logic [31:0] errAddr;
  logic [7:0]  errLanes;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_parity_unit dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrPar(wrPar), .rdData(rdData),
    .rdPar(rdPar), .dataRdy(dataRdy), .isRead(isRead), .parEn(parEn),
    .cycAddr(cycAddr), .clrErr(clrErr), .parErr(parErr), .trapReq(trapReq),
    .errValid(errValid), .errAddr(errAddr), .errLanes(errLanes)
  );

  function automatic logic [7:0] refPar(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One beat driven for one cycle; returns at the negedge after the capturing edge.
  task automatic beat(input logic [63:0] d, input logic [7:0] p, input bit rd,
                      input bit en, input logic [31:0] a, input bit clr);
    @(negedge clk);
    rdData = d; rdPar = p; isRead = rd; parEn = en; cycAddr = a;
    dataRdy = 1'b1; clrErr = clr;
    @(negedge clk);
    dataRdy = 1'b0; clrErr = 1'b0; parEn = 1'b0;
  endtask

  task automatic t_reset();
    chk(parErr == 0 && trapReq == 0, "R10 pulses in reset", {parErr, trapReq}, 0);
    chk(errValid == 0 && errAddr == 0 && errLanes == 0, "R10 record in reset", errAddr, 0);
  endtask

  task automatic t_gen();
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0081};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); wrData = pats[i]; #1;
      chk(wrPar == refPar(pats[i]), "R1 write parity", wrPar, refPar(pats[i]));
    end
  endtask

  task automatic t_clean();
    beat(64'hDEAD_BEEF_0BAD_F00D, refPar(64'hDEAD_BEEF_0BAD_F00D), 1, 1, 32'h100, 0);
    chk(parErr == 0 && trapReq == 0, "R2 clean read", parErr, 0);
  endtask

  task automatic t_lanes();
    logic [63:0] d = 64'h5A5A_1234_C3C3_7777;
    for (int ln = 0; ln < 8; ln++) begin
      beat(d, refPar(d) ^ (8'h1 << ln), 1, 0, 32'h200 + ln, 0);
      chk(parErr == 1, "R11 lane flip detected (R4 enable low)", parErr, 1);
      chk(trapReq == 0 && errValid == 0 && errAddr == 0, "R9 no trap or capture", errAddr, 0);
      @(negedge clk);
      chk(parErr == 0, "R2 pulse one clock", parErr, 0);
    end
  endtask

  task automatic t_noread();
    beat(64'h1, 8'h0, 0, 1, 32'h300, 0);
    chk(parErr == 0 && errValid == 0, "R3 write beat ignored", parErr, 0);
    @(negedge clk); rdData = 64'h1; rdPar = 8'h0; isRead = 1; parEn = 1;
    @(negedge clk);
    chk(parErr == 0 && errValid == 0, "R3 no strobe ignored", parErr, 0);
    isRead = 0; parEn = 0;
  endtask

  task automatic t_trap();
    logic [63:0] d = 64'h0F0F_0F0F_0F0F_0F0F;
    beat(d, refPar(d) ^ 8'h08, 1, 1, 32'hA000_0040, 0);
    chk(parErr == 1 && trapReq == 1, "R5 trap pulse", {parErr, trapReq}, 2'b11);
    chk(errValid == 1 && errAddr == 32'hA000_0040, "R6 address captured", errAddr, 32'hA000_0040);
    chk(errLanes == 8'h08, "R6 lane mask", errLanes, 8'h08);
    @(negedge clk);
    chk(trapReq == 0, "R5 trap one clock", trapReq, 0);
  endtask

  task automatic t_sticky();
    logic [63:0] d = 64'h1111_2222_3333_4444;
    beat(d, refPar(d) ^ 8'h01, 1, 1, 32'hB000_0000, 0);
    chk(parErr == 1 && trapReq == 1, "R7 later error still traps", {parErr, trapReq}, 2'b11);
    chk(errAddr == 32'hA000_0040 && errLanes == 8'h08, "R7 record held", errAddr, 32'hA000_0040);
  endtask

  task automatic t_clear();
    logic [63:0] d = 64'h8000_0000_0000_0000;
    @(negedge clk); clrErr = 1;
    @(negedge clk); clrErr = 0;
    chk(errValid == 0 && errAddr == 0 && errLanes == 0, "R8 clear record", errAddr, 0);
    beat(d, refPar(d), 1, 1, 32'hC1, 0);   // clean, nothing captured
    beat(d, refPar(d) ^ 8'h80, 1, 1, 32'hC000_0008, 1);
    chk(errValid == 1 && errAddr == 32'hC000_0008 && errLanes == 8'h80,
        "R8 capture wins over clear", errAddr, 32'hC000_0008);
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_gen();
    t_clean();
    t_lanes();
    t_noread();
    t_trap();
    t_sticky();
    t_clear();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule